// File: doc/BRIEF.md
# Sensor Byte Drain Port

This block holds the bytes that an auxiliary sensor stream hands to the protocol logic and lets a host take them out, one byte per read, together with a status byte that describes that byte. Bytes enter through a single-cycle valid strobe that carries two producer flags. They wait in an eight-entry queue. When the queue is full, the newest byte replaces the oldest one and the loss is flagged.

The host reads in one of two ways, chosen by an enable input. With the enable set, the host uses a read-only serial slave. It lowers select, clocks sixteen bits, and receives the status byte and then the data byte, most significant bit first. The slave changes its output on the rising clock edge and the host samples on the falling edge. The entry leaves the queue only after all sixteen bits have gone out and select has risen again. With the enable clear, the serial pins are ignored. The head entry's status and data appear on two register-style outputs, and a one-cycle pop input removes the entry.

The upper nibble of every status byte walks through a fixed four-step pattern. The pattern moves on by one for each completed read, so the host can tell a live interface from a stuck or shifted one. Serial pins are oversampled in the system clock domain.

Top module: `sensor_drain_port`

## Requirements
- R1: The queue holds up to 8 entries, each a data byte plus the two producer flags given with it, and returns them in arrival order.
- R2: The status byte is laid out as: bits 7:4 the rolling pattern, bit 3 the empty flag, bit 2 the overflow flag, bits 1:0 the producer flags of the head entry.
- R3: A write into a full queue with no pop in the same cycle drops the oldest entry and sets the overflow flag. A write and a pop in the same cycle on a full queue lose nothing, leave 8 entries and do not set overflow.
- R4: The overflow flag appears in the next status byte that is popped, and is cleared by that pop.
- R5: Serial reads use clock idle low. The output bit changes after each rising clock edge and is valid on the falling edge. A frame is 16 bits: the status byte first, then the data byte, each sent most significant bit first.
- R6: An entry is popped only when exactly 16 rising clock edges occurred while select was low and select then rises. A shorter frame leaves the queue and the pattern unchanged.
- R7: With the queue empty, the status byte has bit 3 set and flags 00, the data byte is 00h, and a read does not change the queue.
- R8: After reset the pattern is 0101, and it then steps through 1010, 0011, 1100 and back to 0101. It advances once per completed read, serial or register.
- R9: With the enable clear, MISO stays low and serial activity pops nothing. The register outputs show the head status and data, and the pop input removes the head. With the enable set, both register outputs read 00h and the pop input is ignored.
- R10: After reset the queue is empty and the overflow flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | One-cycle strobe: store wr_data and wr_flags |
| wr_data | input | 8 | Data byte from the sensor stream |
| wr_flags | input | 2 | Producer flags kept with the byte |
| spi_en | input | 1 | 1: drain through serial port, 0: drain through register outputs |
| spi_sclk | input | 1 | Serial clock from host, idle low |
| spi_ss_n | input | 1 | Serial select from host, active low |
| spi_miso | output | 1 | Serial data to host |
| reg_pop | input | 1 | One-cycle pop of the head entry in register mode |
| reg_status | output | 8 | Head status byte in register mode, else 00h |
| reg_data | output | 8 | Head data byte in register mode, else 00h |

## Verification
A new byte arriving on a full queue can land in the same cycle as a pop. Whether the pop frees a slot or the write overwrites decides both the entry count and the overflow flag. The bench provokes this in register mode by raising the write strobe and the pop input on the same clock with eight entries stored. It then drains the queue and judges the result by the data sequence (first byte gone, newest byte present, exactly eight entries), by the overflow bit staying clear, and by the empty flag appearing after the eighth pop. The separate case of a write landing on a full queue with no pop is checked through the serial path. There the first popped status must carry overflow and the second must not.

// File: rtl/drain_pkg.sv
package drain_pkg;

    localparam int DATA_W    = 8;
    localparam int FLAG_W    = 2;
    localparam int PAT_W     = 4;
    localparam int PAT_STEPS = 4;
    localparam int PAT_IDX_W = $clog2(PAT_STEPS);

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [DATA_W-1:0] data;
    } entry_t;

    // rolling check nibble for step idx of the per-read sequence
    function automatic logic [PAT_W-1:0] pattern_at(input logic [PAT_IDX_W-1:0] idx);
        logic [PAT_W-1:0] p;
        case (idx)
            2'd0:    p = 4'b0101;
            2'd1:    p = 4'b1010;
            2'd2:    p = 4'b0011;
            default: p = 4'b1100;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/drain_fifo.sv
module drain_fifo
    import drain_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push,
    input  entry_t push_entry,
    input  logic   pop,
    input  logic   ovf_clear,
    output entry_t head,
    output logic   empty,
    output logic   full,
    output logic   ovf
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PTR_W-1:0] wptr;
        logic [PTR_W-1:0] rptr;
        logic [CNT_W-1:0] cnt;
        logic             ovf;
    } ctl_t;

    ctl_t   c_d, c_q;
    entry_t mem_q [DEPTH];

    logic do_pop;
    logic is_full;
    logic overwrite;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        c_d       = c_q;
        is_full   = (c_q.cnt == CNT_W'(DEPTH));
        do_pop    = pop && (c_q.cnt != '0);
        // a same-cycle pop makes room, so only a lone write on full overwrites
        overwrite = push && is_full && !do_pop;

        if (push) c_d.wptr = step(c_q.wptr);
        if (do_pop || overwrite) c_d.rptr = step(c_q.rptr);

        if (push && !do_pop && !is_full) c_d.cnt = c_q.cnt + 1'b1;
        else if (do_pop && !push)        c_d.cnt = c_q.cnt - 1'b1;

        c_d.ovf = (c_q.ovf && !ovf_clear) || overwrite;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    always_ff @(posedge clk) begin
        if (push) mem_q[c_q.wptr] <= push_entry;
    end

    assign head  = mem_q[c_q.rptr];
    assign empty = (c_q.cnt == '0);
    assign full  = (c_q.cnt == CNT_W'(DEPTH));
    assign ovf   = c_q.ovf;

endmodule

// File: rtl/drain_spi_shift.sv
module drain_spi_shift #(
    parameter int FRAME_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               sclk,
    input  logic               ss_n,
    input  logic [FRAME_W-1:0] load_word,
    output logic               miso,
    output logic               start,
    output logic               done
);

    localparam int CNT_W = $clog2(FRAME_W + 2);

    typedef struct packed {
        logic [1:0]         sclk_s;
        logic [1:0]         ss_s;
        logic               sclk_p;
        logic               ss_p;
        logic               in_frame;
        logic [FRAME_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        logic               bit_out;
    } sh_t;

    sh_t  s_d, s_q;
    logic ss_fall, ss_rise, sck_rise;

    always_comb begin
        s_d      = s_q;
        start    = 1'b0;
        done     = 1'b0;

        s_d.sclk_s = {s_q.sclk_s[0], sclk};
        s_d.ss_s   = {s_q.ss_s[0], ss_n};
        s_d.sclk_p = s_q.sclk_s[1];
        s_d.ss_p   = s_q.ss_s[1];

        ss_fall  = s_q.ss_p && !s_q.ss_s[1];
        ss_rise  = !s_q.ss_p && s_q.ss_s[1];
        sck_rise = !s_q.sclk_p && s_q.sclk_s[1];

        if (!enable) begin
            s_d.in_frame = 1'b0;
            s_d.bit_out  = 1'b0;
        end else if (ss_fall) begin
            start        = 1'b1;
            s_d.in_frame = 1'b1;
            s_d.shreg    = load_word;
            s_d.cnt      = '0;
            s_d.bit_out  = 1'b0;
        end else if (s_q.in_frame) begin
            if (ss_rise) begin
                s_d.in_frame = 1'b0;
                s_d.bit_out  = 1'b0;
                done         = (s_q.cnt == CNT_W'(FRAME_W));
            end else if (sck_rise) begin
                // leading edge: present next bit, host samples on trailing edge
                s_d.bit_out = s_q.shreg[FRAME_W-1];
                s_d.shreg   = {s_q.shreg[FRAME_W-2:0], 1'b0};
                if (s_q.cnt != CNT_W'(FRAME_W + 1)) s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.ss_s <= 2'b11;
            s_q.ss_p <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign miso = s_q.bit_out && s_q.in_frame && enable;

endmodule

// File: rtl/sensor_drain_port.sv
module sensor_drain_port
    import drain_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic              spi_en,
    input  logic              spi_sclk,
    input  logic              spi_ss_n,
    output logic              spi_miso,
    input  logic              reg_pop,
    output logic [DATA_W-1:0] reg_status,
    output logic [DATA_W-1:0] reg_data
);

    localparam int FRAME_W = 2 * DATA_W;

    typedef struct packed {
        logic [PAT_IDX_W-1:0] pat_idx;
        logic                 cap_ovf;
    } top_t;

    top_t   t_d, t_q;
    entry_t head;
    entry_t push_entry;
    logic   fifo_empty, fifo_full, fifo_ovf;
    logic   spi_start, spi_done;
    logic   reg_mode_pop, pop_any, ovf_clear;
    logic [DATA_W-1:0] status_now, data_now;

    assign push_entry = '{flags: wr_flags, data: wr_data};

    always_comb begin
        t_d          = t_q;
        reg_mode_pop = reg_pop && !spi_en;
        pop_any      = spi_done || reg_mode_pop;

        status_now = {pattern_at(t_q.pat_idx), fifo_empty, fifo_ovf,
                      fifo_empty ? {FLAG_W{1'b0}} : head.flags};
        data_now   = fifo_empty ? '0 : head.data;

        // clear only the overflow value that the popped status actually carried
        if (spi_done)          ovf_clear = t_q.cap_ovf;
        else if (reg_mode_pop) ovf_clear = fifo_ovf;
        else                   ovf_clear = 1'b0;

        if (spi_start) t_d.cap_ovf = fifo_ovf;
        if (pop_any)   t_d.pat_idx = t_q.pat_idx + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    drain_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (wr_valid),
        .push_entry (push_entry),
        .pop        (pop_any),
        .ovf_clear  (ovf_clear),
        .head       (head),
        .empty      (fifo_empty),
        .full       (fifo_full),
        .ovf        (fifo_ovf)
    );

    drain_spi_shift #(.FRAME_W(FRAME_W)) i_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (spi_en),
        .sclk      (spi_sclk),
        .ss_n      (spi_ss_n),
        .load_word ({status_now, data_now}),
        .miso      (spi_miso),
        .start     (spi_start),
        .done      (spi_done)
    );

    assign reg_status = spi_en ? '0 : status_now;
    assign reg_data   = spi_en ? '0 : data_now;

endmodule

// File: rtl/drain_port_checker.sv
module drain_port_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_en,
    input logic       spi_miso,
    input logic       reg_pop,
    input logic [7:0] reg_status,
    input logic [7:0] reg_data,
    input logic       wr_valid,
    input logic       fifo_full,
    input logic       fifo_ovf,
    input logic       pop_any
);

    // R9: serial output silent while the register path is selected
    p_miso_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_en |-> !spi_miso);

    // R9: register outputs read zero while the serial path is selected
    p_reg_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        spi_en |-> (reg_status == 8'h00 && reg_data == 8'h00));

    // R7: empty status always comes with a zero data byte
    p_empty_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_en && reg_status[3]) |-> (reg_data == 8'h00 && reg_status[1:0] == 2'b00));

    // R8: a register pop moves the check nibble
    p_pattern_steps_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!spi_en && reg_pop) |=> (reg_status[7:4] != $past(reg_status[7:4])));

    // R3: a lone write on a full queue raises overflow
    p_overwrite_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_valid && !pop_any) |=> fifo_ovf);

    // R3: a write paired with a pop keeps the queue full
    p_pair_keeps_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full && wr_valid && pop_any) |=> fifo_full);

endmodule

bind sensor_drain_port drain_port_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .spi_en     (spi_en),
    .spi_miso   (spi_miso),
    .reg_pop    (reg_pop),
    .reg_status (reg_status),
    .reg_data   (reg_data),
    .wr_valid   (wr_valid),
    .fifo_full  (fifo_full),
    .fifo_ovf   (fifo_ovf),
    .pop_any    (pop_any)
);

// File: tb/test_sensor_drain_port.sv
module test_sensor_drain_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] wr_flags = '0;
    logic       spi_en = 1'b0;
    logic       spi_sclk = 1'b0;
    logic       spi_ss_n = 1'b1;
    logic       spi_miso;
    logic       reg_pop = 1'b0;
    logic [7:0] reg_status, reg_data;

    int checks = 0;
    int errors = 0;
    int txn = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sensor_drain_port i_sensor_drain_port (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_flags(wr_flags), .spi_en(spi_en), .spi_sclk(spi_sclk),
        .spi_ss_n(spi_ss_n), .spi_miso(spi_miso), .reg_pop(reg_pop),
        .reg_status(reg_status), .reg_data(reg_data)
    );

    // {flags, data}
    localparam logic [9:0] VEC [0:5] = '{10'h1A5, 10'h03C, 10'h2FF, 10'h300, 10'h181, 10'h07E};

    function automatic logic [3:0] exp_pat(input int n);
        case (n % 4)
            0: return 4'b0101;
            1: return 4'b1010;
            2: return 4'b0011;
            default: return 4'b1100;
        endcase
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [1:0] f);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_flags = f;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic spi_read(input int nbits, output logic [15:0] word, output logic any_high);
        word = '0; any_high = 1'b0;
        @(negedge clk);
        spi_ss_n = 1'b0;
        repeat (8) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            spi_sclk = 1'b1;
            repeat (8) @(negedge clk);
            word = {word[14:0], spi_miso};
            any_high |= spi_miso;
            spi_sclk = 1'b0;
            repeat (8) @(negedge clk);
        end
        spi_ss_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic pop_reg;
        @(negedge clk);
        reg_pop = 1'b1;
        @(negedge clk);
        reg_pop = 1'b0;
        txn++;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        logic hi;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 / R7: reset state, register view
        check("R10 reset status", {8'h00, reg_status}, {8'h00, 4'b0101, 4'b1000});
        check("R7 reset data", {8'h00, reg_data}, 16'h0000);
        check("R9 miso idle", {15'h0, spi_miso}, 16'h0000);

        // R1 R2 R5 R8: table of entries, drained over serial
        for (int k = 0; k < 6; k++) push(VEC[k][7:0], VEC[k][9:8]);
        spi_en = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 reg quiet", {reg_status, reg_data}, 16'h0000);
        for (int k = 0; k < 6; k++) begin
            spi_read(16, w, hi);
            check("R1 R2 R5 R8 table read", w,
                  {exp_pat(txn), 1'b0, 1'b0, VEC[k][9:8], VEC[k][7:0]});
            txn++;
        end

        // R7: empty read
        spi_read(16, w, hi);
        check("R7 empty read", w, {exp_pat(txn), 4'b1000, 8'h00});
        txn++;

        // R6: short frame pops nothing and keeps pattern
        push(8'hC3, 2'b10);
        spi_read(9, w, hi);
        spi_read(16, w, hi);
        check("R6 after short frame", w, {exp_pat(txn), 4'b0010, 8'hC3});
        txn++;

        // R3 R4: overflow on ninth write
        for (int k = 0; k < 9; k++) push(8'h10 + 8'(k), 2'(k));
        spi_read(16, w, hi);
        check("R3 R4 first after overflow", w, {exp_pat(txn), 2'b01, 2'b01, 8'h11});
        txn++;
        for (int k = 2; k < 9; k++) begin
            spi_read(16, w, hi);
            check("R4 R1 drain after overflow", w, {exp_pat(txn), 2'b00, 2'(k), 8'h10 + 8'(k)});
            txn++;
        end
        spi_read(16, w, hi);
        check("R3 only one lost", w, {exp_pat(txn), 4'b1000, 8'h00});
        txn++;

        // R9: register mode
        spi_en = 1'b0;
        push(8'h5A, 2'b10);
        check("R9 reg status", {8'h00, reg_status}, {8'h00, exp_pat(txn), 4'b0010});
        check("R9 reg data", {8'h00, reg_data}, 16'h005A);
        spi_read(16, w, hi);
        check("R9 serial ignored miso", {15'h0, hi}, 16'h0000);
        check("R9 serial ignored no pop", {reg_status, reg_data}, {exp_pat(txn), 4'b0010, 8'h5A});
        pop_reg();
        check("R9 R8 reg after pop", {reg_status, reg_data}, {exp_pat(txn), 4'b1000, 8'h00});
        spi_en = 1'b1;
        @(negedge clk); reg_pop = 1'b1;
        @(negedge clk); reg_pop = 1'b0;
        spi_en = 1'b0;
        @(negedge clk);
        check("R9 pop ignored when serial", {8'h00, reg_status}, {8'h00, exp_pat(txn), 4'b1000});

        // R3: write and pop in the same cycle on a full queue
        for (int k = 0; k < 8; k++) push(8'h20 + 8'(k), 2'b00);
        check("R3 full head", {8'h00, reg_data}, 16'h0020);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = 8'h28; wr_flags = 2'b11; reg_pop = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0; reg_pop = 1'b0;
        txn++;
        check("R3 pair no overflow", {reg_status, reg_data}, {exp_pat(txn), 4'b0000, 8'h21});
        for (int k = 1; k < 8; k++) begin
            check("R3 R1 pair drain", {8'h00, reg_data}, {8'h00, 8'h20 + 8'(k)});
            pop_reg();
        end
        check("R3 newest kept", {reg_status, reg_data}, {exp_pat(txn), 4'b0011, 8'h28});
        pop_reg();
        check("R3 eight entries", {8'h00, reg_status}, {8'h00, exp_pat(txn), 4'b1000});

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule